// File: doc/BRIEF.md
# Conversion Sequencer with Sleep and Resynchronization Control

This controller steps a converter through eight logical channels, one at a time. For each channel it issues a start pulse to the conversion datapath and then waits for that channel's done handshake. When the eighth channel finishes, it emits a one-cycle scan-complete pulse and wraps back to the first channel. The modulator, digital filter and line-noise-rejection filters exist here only as control signals.

Two paths resynchronize the conversion process.

- **Sleep.** Raising the control-register sleep bit halts conversion. It forces the channel pointer back to the first channel and holds the four rejection-filter clears. Dropping the bit restarts conversion from the first channel.
- **Calibration-memory access.** A host access to calibration memory halts conversion and holds the modulator and filter in reset for as long as the access lasts. Conversion then resumes at the current channel with no further host action.

A saturating scan tally drives a settled flag. With line-noise rejection enabled, four clean scans are needed before the flag rises.

The states are:

- `ST_START`: issue the start pulse.
- `ST_WAIT`: wait for the done handshake.
- `ST_SLEEP`: halted by the sleep bit.
- `ST_CAL`: halted during a calibration access.

The transitions are:

- START→WAIT: always, unless halted.
- WAIT→START: on conv_done.
- Any state→SLEEP: when sleep_bit is high.
- Any state except SLEEP→CAL: when cal_req is high and sleep_bit is low.
- SLEEP→CAL: sleep_bit falls while cal_req is still high.
- SLEEP→START: sleep_bit falls with no access pending.
- CAL→START: cal_req falls.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the sequencer is in ST_START: channel code 0 (logical channel 1), conv_start high, settled low, no resets, no clears, no acknowledge.
- R2: conv_start is high for exactly the one cycle spent in ST_START. A conv_done seen in ST_WAIT advances the channel code by one (code k-1 means logical channel k) and returns to ST_START.
- R3: scan_done is high for one cycle, only while conv_done is accepted on channel code 7. The channel code becomes 0 on the next cycle.
- R4: While the sleep bit is high, the sequencer sits in ST_SLEEP. In that state the channel code is 0, all four lnr_clr bits are 1, and neither conv_start nor scan_done is ever high, even when conv_done is high.
- R5: When the sleep bit falls with no calibration access pending, the next cycle is ST_START on channel code 0, wherever the scan had stopped.
- R6: With the sleep bit low, cal_req high moves the sequencer to ST_CAL on the next edge. There, mod_rst, filt_rst and cal_ack stay high until cal_req falls. The sequencer then returns to ST_START on the same channel code.
- R7: A cal_req raised while in ST_SLEEP is acknowledged (cal_ack high) but does not restart conversion. If cal_req is still high when the sleep bit falls, the sequencer enters ST_CAL.
- R8: settled is high once the scan tally reaches its threshold: 4 completed scans when lnr_en is 1, and 1 scan when lnr_en is 0. The tally saturates, so further scans keep settled high.
- R9: A cycle with the sleep bit high, a cycle with cal_req high, or a reset clears the scan tally. settled is low on the following cycle.
- R10: Priority is sleep over calibration access over conv_done. A conv_done that coincides with either halt does not advance the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sleep_bit | input | 1 | Sleep bit of the control register |
| cal_req | input | 1 | Host calibration-memory access in progress |
| lnr_en | input | 1 | Line-noise rejection enabled |
| conv_done | input | 1 | Per-channel conversion-done handshake |
| conv_start | output | 1 | Start conversion of the current channel |
| mod_rst | output | 1 | Modulator reset |
| filt_rst | output | 1 | Digital filter reset |
| lnr_clr | output | 4 | Clears for the four rejection filters |
| cal_ack | output | 1 | Calibration access acknowledged |
| chan | output | 3 | Current channel code (0 = logical channel 1) |
| scan_done | output | 1 | One-cycle scan-complete pulse |
| settled | output | 1 | Rejection settling complete |

## Verification
The hardest situations to reach are the overlaps between the halt paths:

- a calibration request that arrives during sleep and is still active when sleep ends;
- a conv_done that lands in the same cycle as a halt.

A cycle-by-cycle vector table drives these overlaps directly. Directed runs of four and five full scans then reach the settled threshold and its saturation. Each halt is then applied from mid-scan and from the settled state, to show both the pointer reset and the tally clear at the ports.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_CAL   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/conv_chan_ptr.sv
module conv_chan_ptr #(
    parameter int NUM_CH = 8,
    localparam int PW = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [PW-1:0] ptr,
    output logic          last
);
    assign last = (ptr == PW'(NUM_CH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= last ? '0 : ptr + PW'(1);
        end
    end
endmodule

// File: rtl/conv_scan_tally.sv
module conv_scan_tally #(
    parameter int LIMIT = 4,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CW'(LIMIT))) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int NUM_LNR      = 4,
    parameter int SETTLE_SCANS = 4,
    localparam int PW = $clog2(NUM_CH),
    localparam int CW = $clog2(SETTLE_SCANS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_bit,
    input  logic               cal_req,
    input  logic               lnr_en,
    input  logic               conv_done,
    output logic               conv_start,
    output logic               mod_rst,
    output logic               filt_rst,
    output logic [NUM_LNR-1:0] lnr_clr,
    output logic               cal_ack,
    output logic [PW-1:0]      chan,
    output logic               scan_done,
    output logic               settled
);
    seq_state_t state_q, state_d;
    logic       ptr_last;
    logic       ptr_adv;
    logic [CW-1:0] tally;
    logic [CW-1:0] settle_thr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    // next-state logic: sleep outranks calibration access, which outranks conv_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: begin
                if (sleep_bit)    state_d = ST_SLEEP;
                else if (cal_req) state_d = ST_CAL;
                else              state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (sleep_bit)      state_d = ST_SLEEP;
                else if (cal_req)   state_d = ST_CAL;
                else if (conv_done) state_d = ST_START;
            end
            ST_SLEEP: begin
                if (!sleep_bit) state_d = cal_req ? ST_CAL : ST_START;
            end
            ST_CAL: begin
                if (sleep_bit)     state_d = ST_SLEEP;
                else if (!cal_req) state_d = ST_START;
            end
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        conv_start = 1'b0;
        mod_rst    = 1'b0;
        filt_rst   = 1'b0;
        cal_ack    = 1'b0;
        lnr_clr    = '0;
        ptr_adv    = 1'b0;
        unique case (state_q)
            ST_START: conv_start = 1'b1;
            ST_WAIT:  ptr_adv = conv_done && !sleep_bit && !cal_req;
            ST_SLEEP: begin
                lnr_clr = '1;
                cal_ack = cal_req;
            end
            ST_CAL: begin
                mod_rst  = 1'b1;
                filt_rst = 1'b1;
                cal_ack  = 1'b1;
            end
        endcase
    end

    assign scan_done = ptr_adv && ptr_last;

    conv_chan_ptr #(.NUM_CH(NUM_CH)) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sleep_bit),
        .adv   (ptr_adv),
        .ptr   (chan),
        .last  (ptr_last)
    );

    conv_scan_tally #(.LIMIT(SETTLE_SCANS)) tally_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sleep_bit || cal_req),
        .inc   (scan_done),
        .count (tally)
    );

    assign settle_thr = lnr_en ? CW'(SETTLE_SCANS) : CW'(1);
    assign settled    = (tally >= settle_thr);
endmodule

// File: rtl/conv_sequencer_checker.sv
module conv_sequencer_checker #(
    parameter int NUM_CH  = 8,
    parameter int NUM_LNR = 4,
    localparam int PW = $clog2(NUM_CH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep_bit,
    input logic               cal_req,
    input logic               conv_start,
    input logic               mod_rst,
    input logic               filt_rst,
    input logic [NUM_LNR-1:0] lnr_clr,
    input logic               cal_ack,
    input logic [PW-1:0]      chan,
    input logic               scan_done,
    input logic               settled
);
    AST_SCAN_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (chan == PW'(NUM_CH - 1)));                           // R3
    AST_SCAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> (chan == '0));                                        // R3
    AST_SLEEP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_bit |=> ((chan == '0) && !conv_start && !scan_done));         // R4
    AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_bit |=> (&lnr_clr));                                          // R4
    AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req && !sleep_bit) |=> (mod_rst && filt_rst && cal_ack && !conv_start)); // R6
    AST_HALT_UNSETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_bit || cal_req) |=> !settled);                               // R9
endmodule

bind conv_sequencer conv_sequencer_checker #(.NUM_CH(NUM_CH), .NUM_LNR(NUM_LNR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_bit  (sleep_bit),
    .cal_req    (cal_req),
    .conv_start (conv_start),
    .mod_rst    (mod_rst),
    .filt_rst   (filt_rst),
    .lnr_clr    (lnr_clr),
    .cal_ack    (cal_ack),
    .chan       (chan),
    .scan_done  (scan_done),
    .settled    (settled)
);

// File: tb/conv_sequencer_tb_top.sv
`timescale 1ns/1ps
module conv_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_bit = 1'b0;
    logic       cal_req = 1'b0;
    logic       lnr_en = 1'b1;
    logic       conv_done = 1'b0;
    logic       conv_start, mod_rst, filt_rst, cal_ack, scan_done, settled;
    logic [3:0] lnr_clr;
    logic [2:0] chan;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    conv_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_bit(sleep_bit), .cal_req(cal_req),
        .lnr_en(lnr_en), .conv_done(conv_done), .conv_start(conv_start),
        .mod_rst(mod_rst), .filt_rst(filt_rst), .lnr_clr(lnr_clr),
        .cal_ack(cal_ack), .chan(chan), .scan_done(scan_done), .settled(settled)
    );

    // vector: sleep cal done | expected after edge: chan start ack mrst clr
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        10'b000_000_0000, // R2 START->WAIT
        10'b001_001_1000, // R2 done advances
        10'b000_001_0000, // R2
        10'b001_010_1000, // R2
        10'b100_000_0001, // R4 sleep from START, pointer to 0
        10'b110_000_0101, // R7 ack while asleep, no restart
        10'b010_000_0110, // R7 sleep exits with access pending -> CAL
        10'b010_000_0110, // R6 held in CAL
        10'b000_000_1000, // R6 auto restart
        10'b000_000_0000, // R2
        10'b011_000_0110, // R10 cal beats conv_done
        10'b000_000_1000, // R6
        10'b110_000_0101, // R10 sleep beats cal
        10'b000_000_1000  // R5 restart at channel 1
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sleep_bit = 1'b0; cal_req = 1'b0; conv_done = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        #1;
    endtask

    // from ST_START: one channel conversion; returns scan_done seen with conv_done
    task automatic run_chan(output logic sd);
        conv_done = 1'b0;
        tick();
        conv_done = 1'b1;
        #1;
        sd = scan_done;
        tick();
        conv_done = 1'b0;
    endtask

    task automatic run_scan();
        logic sd;
        for (int c = 0; c < 8; c++) begin
            run_chan(sd);
            chk("R3 scan_done only on channel 8", int'(sd), (c == 7) ? 1 : 0);
        end
        chk("R3 wrap to channel code 0", int'(chan), 0);
    endtask

    initial begin
        do_reset();
        chk("R1 chan", int'(chan), 0);
        chk("R1 conv_start", int'(conv_start), 1);
        chk("R1 settled", int'(settled), 0);
        chk("R1 no reset/ack/clear", int'({mod_rst, filt_rst, cal_ack, |lnr_clr}), 0);

        for (int i = 0; i < NV; i++) begin
            {sleep_bit, cal_req, conv_done} = VEC[i][9:7];
            tick();
            chk($sformatf("R2/R4-R7/R10 vec%0d chan", i), int'(chan), int'(VEC[i][6:4]));
            chk($sformatf("R2/R5/R6 vec%0d start", i), int'(conv_start), int'(VEC[i][3]));
            chk($sformatf("R6/R7 vec%0d ack", i), int'(cal_ack), int'(VEC[i][2]));
            chk($sformatf("R6 vec%0d mod/filt rst", i), int'(mod_rst & filt_rst), int'(VEC[i][1]));
            chk($sformatf("R4 vec%0d lnr_clr", i), int'(lnr_clr), VEC[i][0] ? 15 : 0);
        end

        // R8: four scans with rejection enabled
        do_reset();
        lnr_en = 1'b1;
        for (int s = 1; s <= 5; s++) begin
            run_scan();
            chk($sformatf("R8 settled after %0d scans", s), int'(settled), (s >= 4) ? 1 : 0);
        end

        // R4/R9: sleep from settled state, conv_done ignored while asleep
        sleep_bit = 1'b1; conv_done = 1'b1;
        tick();
        chk("R9 sleep clears settled", int'(settled), 0);
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R4 no scan_done asleep", int'(scan_done), 0);
            chk("R4 no conv_start asleep", int'(conv_start), 0);
            tick();
        end
        chk("R4 chan held 0", int'(chan), 0);
        chk("R4 lnr_clr all set", int'(lnr_clr), 15);
        sleep_bit = 1'b0; conv_done = 1'b0;
        tick();
        chk("R5 restart after sleep", int'(conv_start), 1);

        // R8: rejection disabled, one scan suffices
        lnr_en = 1'b0;
        run_scan();
        chk("R8 settled after 1 scan lnr off", int'(settled), 1);
        cal_req = 1'b1;
        tick();
        chk("R9 cal clears settled", int'(settled), 0);
        cal_req = 1'b0;
        tick();
        chk("R6 restart after cal", int'(conv_start), 1);

        // R9: reset clears tally
        run_scan();
        chk("R8 settled before reset", int'(settled), 1);
        do_reset();
        chk("R9 reset clears settled", int'(settled), 0);

        // R5: mid-scan sleep restarts from channel 1
        begin
            logic sd;
            for (int c = 0; c < 3; c++) run_chan(sd);
        end
        chk("R2 mid-scan channel", int'(chan), 3);
        sleep_bit = 1'b1;
        tick();
        sleep_bit = 1'b0;
        tick();
        chk("R5 mid-scan restart chan", int'(chan), 0);
        chk("R5 mid-scan restart start", int'(conv_start), 1);

        // R6: calibration access keeps the channel
        begin
            logic sd;
            for (int c = 0; c < 2; c++) run_chan(sd);
        end
        cal_req = 1'b1;
        repeat (3) tick();
        chk("R6 chan kept in CAL", int'(chan), 2);
        chk("R6 mod_rst held", int'(mod_rst), 1);
        cal_req = 1'b0;
        tick();
        chk("R6 resume same chan", int'(chan), 2);
        chk("R6 resume start", int'(conv_start), 1);
        chk("R6 resets released", int'(mod_rst | filt_rst | cal_ack), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule